// File: doc/BRIEF.md
# Microcontroller Sleep Mode Controller

This block decides when a small microcontroller core may stop, which clock domains stay alive while it is stopped, and how it comes back. Software selects a low-power mode through a 3-bit field and arms sleep with an enable bit. The core then issues a one-cycle sleep strobe. While asleep the block gates the CPU, flash, I/O, ADC and asynchronous-timer clocks and the main oscillator according to the mode. It watches the wake requests that the mode allows.

An allowed wake request starts the exit. In the two modes that stop the main oscillator, the block first waits for the oscillator's start-up-done input. It then holds the core halted for a fixed number of cycles with every clock running. Finally it pulses a flag that tells the core to take the interrupt and resume after the sleep instruction. A reset request that arrives while the core is stopped ends sleep in the next cycle and pulses a separate flag that steers the core to the reset vector. An interrupt wake never produces a reset or a clear, so the register file and memory keep their contents.

Mode codes (`sleep_mode_i`): 000 Idle, 001 ADC noise reduction, 010 Power-down, 011 Power-save, 110 Standby, 111 Extended standby. Codes 100 and 101 are reserved. Wake source bits: 0 external pin A, 1 external pin B, 2 pin change, 3 two-wire address match, 4 asynchronous timer, 5 memory-write-ready, 6 ADC conversion done, 7 watchdog, 8 other I/O.

Top module: `sleep_ctrl`

## Requirements
- R1: A sleep strobe moves the block to sleep (core_halt_o high in the next cycle) only when sleep_en_i is 1 in the same cycle. A strobe with sleep_en_i at 0 leaves core_halt_o low.
- R2: Mode codes 100 and 101 are reserved. A strobe with either code does not enter sleep, and core_halt_o stays low.
- R3: Clock enables while asleep, listed as {cpu, flash, io, adc, asy, osc}, are: Idle 001111, ADC noise reduction 000111, Power-down 000000, Power-save 000010, Standby 000001, Extended standby 000011. While awake all six are 1 and core_halt_o is 0.
- R4: Wake sources allowed per mode (bit numbers): Idle 0-8, ADC noise reduction 0-7, Power-down and Standby 0,1,2,3,7, Power-save and Extended standby 0,1,2,3,4,7. A source wakes only when its request and enable bits are both 1.
- R5: In Power-down, Power-save, Standby and Extended standby, sources 0 and 1 wake only when their ext_level_i bit is 1 (level sense). With the bit at 0 (edge sense) the request is ignored.
- R6: The asynchronous-timer source (bit 4) wakes the block in Power-save and Extended standby and is ignored in Power-down.
- R7: After a wake from Power-down or Power-save, the block keeps osc_en_o at 1 and waits until osc_ready_i is 1 before the halt count starts. From any other mode the halt count starts right after the wake, whatever osc_ready_i is.
- R8: The halt count holds core_halt_o at 1 for HALT_CYC (default 4) cycles. In the next cycle core_halt_o is 0 and wake_irq_o is 1 for exactly one cycle.
- R9: core_rst_i at 1 in any cycle in which core_halt_o is 1 makes the next cycle awake (all enables 1, core_halt_o 0), with wake_rst_o high for one cycle and wake_irq_o low.
- R10: A wake request that the selected mode allows, present in the same cycle as a qualifying sleep strobe, cancels entry, and core_halt_o stays low.
- R11: A wake by interrupt never raises wake_rst_o.
- R12: During the halt count all five clock enables and osc_en_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sleep_en_i | input | 1 | Sleep-enable control bit |
| sleep_mode_i | input | 3 | Mode select field |
| sleep_stb_i | input | 1 | One-cycle sleep-instruction strobe from the core |
| wake_req_i | input | 9 | Per-source wake requests |
| wake_en_i | input | 9 | Per-source wake enables |
| ext_level_i | input | 2 | Sense of external pins A/B: 1 level, 0 edge |
| core_rst_i | input | 1 | Reset request from the chip reset logic |
| osc_ready_i | input | 1 | Main oscillator start-up done |
| clk_cpu_en_o | output | 1 | CPU clock enable |
| clk_flash_en_o | output | 1 | Flash clock enable |
| clk_io_en_o | output | 1 | I/O clock enable |
| clk_adc_en_o | output | 1 | ADC clock enable |
| clk_asy_en_o | output | 1 | Asynchronous timer clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| core_halt_o | output | 1 | Core halted |
| wake_irq_o | output | 1 | One-cycle pulse: resume through the interrupt |
| wake_rst_o | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
The bench aims at the moments where timing or qualification can slip. It checks a wake raised in the same cycle as the strobe, which a design that lets entry win would turn into a sleep that never ends. It checks edge-configured pin requests and timer requests in the deep modes, which a loose mask would let through. It checks the start-up wait in the oscillator-off modes against the modes that skip it: an off-by-one or a skipped wait shows up as a halt window of the wrong length. It also checks a reset request that lands during start-up or the halt count, which must not also yield an interrupt pulse.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  localparam int NSRC = 9;
  localparam int MODE_W = 3;

  localparam int SRC_PIN_A = 0;
  localparam int SRC_PIN_B = 1;
  localparam int SRC_PCHG  = 2;
  localparam int SRC_TWI   = 3;
  localparam int SRC_ATMR  = 4;
  localparam int SRC_MEMRD = 5;
  localparam int SRC_ADC   = 6;
  localparam int SRC_WDOG  = 7;
  localparam int SRC_MISC  = 8;

  localparam logic [MODE_W-1:0] M_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] M_ADCNR = 3'b001;
  localparam logic [MODE_W-1:0] M_PDOWN = 3'b010;
  localparam logic [MODE_W-1:0] M_PSAVE = 3'b011;
  localparam logic [MODE_W-1:0] M_STBY  = 3'b110;
  localparam logic [MODE_W-1:0] M_XSTBY = 3'b111;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HALT  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
    logic osc;
  } clk_en_t;

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return (m != 3'b100) && (m != 3'b101);
  endfunction

  function automatic logic mode_deep(input logic [MODE_W-1:0] m);
    return (m == M_PDOWN) || (m == M_PSAVE) || (m == M_STBY) || (m == M_XSTBY);
  endfunction

  function automatic logic mode_osc_off(input logic [MODE_W-1:0] m);
    return (m == M_PDOWN) || (m == M_PSAVE);
  endfunction

  function automatic logic src_allowed(input logic [MODE_W-1:0] m, input int src);
    logic base;
    base = (src == SRC_PIN_A) || (src == SRC_PIN_B) || (src == SRC_PCHG) ||
           (src == SRC_TWI) || (src == SRC_WDOG);
    case (m)
      M_IDLE:           return 1'b1;
      M_ADCNR:          return src != SRC_MISC;
      M_PDOWN, M_STBY:  return base;
      M_PSAVE, M_XSTBY: return base || (src == SRC_ATMR);
      default:          return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
  import sleep_ctrl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [1:0]        ext_level_i,
  output logic              wake_o
);

  logic [NSRC-1:0] hit;
  logic            deep;

  assign deep = mode_deep(mode_i);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SRC_PIN_A || i == SRC_PIN_B) begin : g_pin
      // edge-sensed pins cannot wake the deep modes
      assign hit[i] = req_i[i] && en_i[i] && src_allowed(mode_i, i) &&
                      (!deep || ext_level_i[i]);
    end else begin : g_oth
      assign hit[i] = req_i[i] && en_i[i] && src_allowed(mode_i, i);
    end
  end

  assign wake_o = |hit;

endmodule

// File: rtl/sleep_clk_map.sv
module sleep_clk_map
  import sleep_ctrl_pkg::*;
(
  input  seq_st_e           st_i,
  input  logic [MODE_W-1:0] mode_i,
  output clk_en_t           en_o
);

  clk_en_t asleep;

  always_comb begin
    asleep = '0;
    case (mode_i)
      M_IDLE:  begin asleep.io = 1'b1; asleep.adc = 1'b1; asleep.asy = 1'b1; asleep.osc = 1'b1; end
      M_ADCNR: begin asleep.adc = 1'b1; asleep.asy = 1'b1; asleep.osc = 1'b1; end
      M_PSAVE: asleep.asy = 1'b1;
      M_STBY:  asleep.osc = 1'b1;
      M_XSTBY: begin asleep.asy = 1'b1; asleep.osc = 1'b1; end
      default: asleep = '0;
    endcase
  end

  always_comb begin
    unique case (st_i)
      ST_SLEEP: en_o = asleep;
      ST_START: begin
        en_o     = asleep;
        en_o.osc = 1'b1;
      end
      default:  en_o = '1;
    endcase
  end

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_ctrl_pkg::*;
#(
  parameter int HALT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              sen_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              cancel_i,
  input  logic              wake_i,
  input  logic              core_rst_i,
  input  logic              osc_ready_i,
  output seq_st_e           st_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o,
  output logic              rst_o
);

  localparam int CNT_W = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_CYC - 1);

  seq_st_e           st_q, st_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              irq_d, rst_d, irq_q, rst_q;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    rst_d  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stb_i && sen_i && mode_valid(mode_sel_i) && !cancel_i) begin
          st_d   = ST_SLEEP;
          mode_d = mode_sel_i;
        end
      end
      ST_SLEEP: begin
        if (core_rst_i) begin
          st_d  = ST_RUN;
          rst_d = 1'b1;
        end else if (wake_i) begin
          cnt_d = '0;
          st_d  = mode_osc_off(mode_q) ? ST_START : ST_HALT;
        end
      end
      ST_START: begin
        if (core_rst_i) begin
          st_d  = ST_RUN;
          rst_d = 1'b1;
        end else if (osc_ready_i) begin
          cnt_d = '0;
          st_d  = ST_HALT;
        end
      end
      ST_HALT: begin
        if (core_rst_i) begin
          st_d  = ST_RUN;
          rst_d = 1'b1;
        end else if (cnt_q == CNT_LAST) begin
          st_d  = ST_RUN;
          irq_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      mode_q <= M_IDLE;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
      rst_q  <= rst_d;
    end
  end

  assign st_o   = st_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;
  assign rst_o  = rst_q;

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int HALT_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sleep_en_i,
  input  logic [2:0]  sleep_mode_i,
  input  logic        sleep_stb_i,
  input  logic [8:0]  wake_req_i,
  input  logic [8:0]  wake_en_i,
  input  logic [1:0]  ext_level_i,
  input  logic        core_rst_i,
  input  logic        osc_ready_i,
  output logic        clk_cpu_en_o,
  output logic        clk_flash_en_o,
  output logic        clk_io_en_o,
  output logic        clk_adc_en_o,
  output logic        clk_asy_en_o,
  output logic        osc_en_o,
  output logic        core_halt_o,
  output logic        wake_irq_o,
  output logic        wake_rst_o
);

  seq_st_e           st;
  logic [MODE_W-1:0] mode_q;
  logic              cancel, wake;
  clk_en_t           en;

  // requests against the mode being requested: cancels entry
  sleep_wake_qual u_qual_entry (
    .mode_i      (sleep_mode_i),
    .req_i       (wake_req_i),
    .en_i        (wake_en_i),
    .ext_level_i (ext_level_i),
    .wake_o      (cancel)
  );

  // requests against the mode in force
  sleep_wake_qual u_qual_sleep (
    .mode_i      (mode_q),
    .req_i       (wake_req_i),
    .en_i        (wake_en_i),
    .ext_level_i (ext_level_i),
    .wake_o      (wake)
  );

  sleep_seq #(.HALT_CYC(HALT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (sleep_stb_i),
    .sen_i       (sleep_en_i),
    .mode_sel_i  (sleep_mode_i),
    .cancel_i    (cancel),
    .wake_i      (wake),
    .core_rst_i  (core_rst_i),
    .osc_ready_i (osc_ready_i),
    .st_o        (st),
    .mode_o      (mode_q),
    .irq_o       (wake_irq_o),
    .rst_o       (wake_rst_o)
  );

  sleep_clk_map u_map (
    .st_i   (st),
    .mode_i (mode_q),
    .en_o   (en)
  );

  assign clk_cpu_en_o   = en.cpu;
  assign clk_flash_en_o = en.flash;
  assign clk_io_en_o    = en.io;
  assign clk_adc_en_o   = en.adc;
  assign clk_asy_en_o   = en.asy;
  assign osc_en_o       = en.osc;
  assign core_halt_o    = (st != ST_RUN);

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_en_i,
  input logic [2:0] sleep_mode_i,
  input logic       sleep_stb_i,
  input logic       core_rst_i,
  input logic       clk_cpu_en_o,
  input logic       clk_flash_en_o,
  input logic       clk_io_en_o,
  input logic       clk_adc_en_o,
  input logic       osc_en_o,
  input logic       core_halt_o,
  input logic       wake_irq_o,
  input logic       wake_rst_o
);

  AST_NO_SLEEP_WO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_halt_o && !(sleep_stb_i && sleep_en_i)) |=> !core_halt_o); // R1

  AST_RESERVED_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_halt_o && (sleep_mode_i == 3'b100 || sleep_mode_i == 3'b101)) |=> !core_halt_o); // R2

  AST_OSC_OFF_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !(clk_cpu_en_o || clk_flash_en_o || clk_io_en_o || clk_adc_en_o)); // R3

  AST_CPU_GATED_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_cpu_en_o |-> core_halt_o); // R3

  AST_IRQ_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> (!core_halt_o && $past(core_halt_o))); // R8

  AST_RST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_halt_o && core_rst_i) |=> (!core_halt_o && wake_rst_o && !wake_irq_o)); // R9

  AST_IRQ_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> !wake_rst_o); // R11

  AST_HALT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_halt_o && clk_cpu_en_o) |-> (clk_flash_en_o && clk_io_en_o && clk_adc_en_o && osc_en_o)); // R12

endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (.*);

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sen = 1'b0;
  logic [2:0] smode = 3'b000;
  logic       stb = 1'b0;
  logic [8:0] wreq = '0;
  logic [8:0] wen = '0;
  logic [1:0] lvl = '0;
  logic       crst = 1'b0;
  logic       ordy = 1'b0;
  logic cpu, fla, io, adc, asy, osc, halt, irq, rsto;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sleep_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_en_i(sen), .sleep_mode_i(smode),
    .sleep_stb_i(stb), .wake_req_i(wreq), .wake_en_i(wen), .ext_level_i(lvl),
    .core_rst_i(crst), .osc_ready_i(ordy),
    .clk_cpu_en_o(cpu), .clk_flash_en_o(fla), .clk_io_en_o(io), .clk_adc_en_o(adc),
    .clk_asy_en_o(asy), .osc_en_o(osc), .core_halt_o(halt),
    .wake_irq_o(irq), .wake_rst_o(rsto)
  );

  // ---- reference model from the requirements ----
  function automatic bit m_valid(input logic [2:0] m);
    return !(m == 3'b100 || m == 3'b101);
  endfunction

  function automatic logic [8:0] m_allow(input logic [2:0] m);
    case (m)
      3'b000: return 9'h1FF;
      3'b001: return 9'h0FF;
      3'b010, 3'b110: return 9'h08F;
      3'b011, 3'b111: return 9'h09F;
      default: return 9'h000;
    endcase
  endfunction

  function automatic bit m_wake(input logic [2:0] m, input logic [8:0] r,
                                input logic [8:0] e, input logic [1:0] l);
    logic [8:0] h;
    h = r & e & m_allow(m);
    if (m == 3'b010 || m == 3'b011 || m == 3'b110 || m == 3'b111)
      h[1:0] = h[1:0] & l;
    return |h;
  endfunction

  function automatic logic [5:0] m_map(input logic [2:0] m);
    case (m)
      3'b000: return 6'b001111;
      3'b001: return 6'b000111;
      3'b011: return 6'b000010;
      3'b110: return 6'b000001;
      3'b111: return 6'b000011;
      default: return 6'b000000;
    endcase
  endfunction

  int         m_st;   // 0 run, 1 sleep, 2 start-up, 3 halt
  logic [2:0] m_mode;
  int         m_cnt;
  bit         m_irq, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_mode <= 3'b000; m_cnt <= 0; m_irq <= 1'b0; m_rst <= 1'b0;
    end else begin
      m_irq <= 1'b0;
      m_rst <= 1'b0;
      case (m_st)
        0: if (stb && sen && m_valid(smode) && !m_wake(smode, wreq, wen, lvl)) begin
             m_st <= 1; m_mode <= smode;
           end
        1: if (crst) begin m_st <= 0; m_rst <= 1'b1; end
           else if (m_wake(m_mode, wreq, wen, lvl)) begin
             m_cnt <= 0;
             m_st  <= (m_mode == 3'b010 || m_mode == 3'b011) ? 2 : 3;
           end
        2: if (crst) begin m_st <= 0; m_rst <= 1'b1; end
           else if (ordy) begin m_cnt <= 0; m_st <= 3; end
        default: if (crst) begin m_st <= 0; m_rst <= 1'b1; end
           else if (m_cnt == 3) begin m_st <= 0; m_irq <= 1'b1; end
           else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  function automatic logic [8:0] m_out();
    logic [5:0] e;
    case (m_st)
      0: return {6'b111111, 1'b0, m_irq, m_rst};
      1: return {m_map(m_mode), 1'b1, 2'b00};
      2: begin e = m_map(m_mode); e[0] = 1'b1; return {e, 1'b1, 2'b00}; end
      default: return {6'b111111, 1'b1, 2'b00};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] dut_out();
    return {cpu, fla, io, adc, asy, osc, halt, irq, rsto};
  endfunction

  // advance one clock, compare all outputs against the model
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, dut_out(), m_out());
  endtask

  task automatic enter(input logic [2:0] m, input string tag);
    sen = 1'b1; smode = m; stb = 1'b1;
    step(tag);
    stb = 1'b0;
  endtask

  task automatic clr_in();
    stb = 1'b0; wreq = '0; crst = 1'b0;
  endtask

  initial begin
    int hcnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R3 reset state", dut_out(), 9'b111111_0_00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: strobe without enable
    sen = 1'b0; smode = 3'b000; stb = 1'b1;
    step("R1 strobe ignored");
    chk("R1 halt low", {8'b0, halt}, 9'd0);
    stb = 1'b0;

    // R2: reserved codes
    enter(3'b100, "R2 code 100");
    enter(3'b101, "R2 code 101");
    chk("R2 halt low", {8'b0, halt}, 9'd0);

    // R3/R8/R12/R11: idle, watchdog wake, count halt cycles
    wen = 9'h1FF;
    enter(3'b000, "R3 idle map");
    chk("R3 idle enables", dut_out(), 9'b001111_1_00);
    wreq = 9'h080;
    step("R12 halt clocks");
    wreq = '0;
    hcnt = 1;
    while (halt && hcnt < 20) begin step("R8 halt window"); if (halt) hcnt++; end
    chk("R8 halt cycles", 9'(hcnt), 9'd4);
    chk("R11 irq pulse only", {7'b0, irq, rsto}, 9'b000000010);
    step("R8 irq one cycle");

    // R10: wake in the strobe cycle cancels entry
    wreq = 9'h004; sen = 1'b1; smode = 3'b010; stb = 1'b1;
    step("R10 cancel");
    chk("R10 still awake", {8'b0, halt}, 9'd0);
    clr_in();

    // R5/R6/R7: power-down, edge pins and timer ignored, start-up wait
    lvl = 2'b00; ordy = 1'b0;
    enter(3'b010, "R3 power-down map");
    wreq = 9'h003; step("R5 edge pins ignored");
    wreq = 9'h010; step("R6 timer ignored in power-down");
    chk("R6 still asleep", dut_out(), 9'b000000_1_00);
    lvl = 2'b01; wreq = 9'h001; step("R5 level pin wakes");
    wreq = '0;
    repeat (3) step("R7 waiting for oscillator");
    chk("R7 osc on and halted", dut_out(), 9'b000001_1_00);
    ordy = 1'b1;
    repeat (6) step("R7 R8 after start-up");
    ordy = 1'b0;

    // R6: power-save timer wake
    enter(3'b011, "R3 power-save map");
    wreq = 9'h010; step("R6 timer wakes power-save");
    wreq = '0; ordy = 1'b1;
    repeat (6) step("R6 exit");
    ordy = 1'b0;

    // R7: standby skips start-up
    lvl = 2'b00;
    enter(3'b110, "R3 standby map");
    wreq = 9'h002; step("R5 standby edge pin ignored");
    wreq = 9'h004; step("R7 standby wake");
    wreq = '0;
    hcnt = 1;
    while (halt && hcnt < 20) begin step("R7 standby halt"); if (halt) hcnt++; end
    chk("R7 no start-up wait", 9'(hcnt), 9'd4);

    // R9: reset in sleep, in start-up and in halt
    enter(3'b111, "R3 ext standby map");
    crst = 1'b1; step("R9 reset in sleep"); crst = 1'b0;
    chk("R9 reset pulse", dut_out(), 9'b111111_0_01);
    enter(3'b010, "R9 setup");
    lvl = 2'b11; wreq = 9'h001; step("R9 wake"); wreq = '0;
    crst = 1'b1; step("R9 reset in start-up"); crst = 1'b0;
    enter(3'b001, "R3 adc noise map");
    wreq = 9'h040; step("R4 adc wakes"); wreq = '0;
    step("R9 halting");
    crst = 1'b1; step("R9 reset in halt"); crst = 1'b0;
    step("R9 after");

    // constrained random against the model
    for (int seg = 0; seg < 15; seg++) begin
      wen = 9'($urandom);
      for (int c = 0; c < 200; c++) begin
        sen   = ($urandom % 8) != 0;
        smode = 3'($urandom);
        stb   = ($urandom % 6) == 0;
        wreq  = (($urandom % 8) == 0) ? (9'd1 << ($urandom % 9)) : 9'd0;
        lvl   = 2'($urandom);
        crst  = ($urandom % 64) == 0;
        ordy  = ($urandom % 4) == 0;
        step("R4 random");
      end
    end
    clr_in();
    step("R4 final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule